// File: doc/BRIEF.md
# Character Display Power-Up Sequencer

This block sits on the host side of a 20-column, 4-row character display. It drives a separate bus cycle generator through a request/done handshake. After reset it waits out the display's power-up time. It then sends the fixed set-up commands, each followed by the settling time that command needs. Busy polling is never used: every wait is a cycle count derived from parameters.

Once set-up is finished the block raises `ready`. It then accepts one character at a time, given as a zero-based row and column. Each accepted character becomes two commands:

- a display-memory address command, with the row mapped onto the display's interleaved memory layout;
- a data write carrying the character.

Rows or columns outside the visible area are refused with a one-cycle error pulse. Line count, font, display/cursor/blink enables, address direction and shift-on-write are fixed by parameters.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is asserted, `cmd_req`, `ready` and `wr_err` are low. After reset is released, the first request rises exactly `PWRUP_CYC` cycles later.
- R2: The set-up commands, all with `cmd_rs`=0, are issued in this order:
  - mode byte `0011_N_F_00` (N=`TWO_LINE`, F=`BIG_FONT`; 38h with defaults);
  - display control byte `00001_D_C_B` (0Ch with defaults);
  - clear byte 01h;
  - entry byte `000001_I_S` (I=`INCR`, S=`SHIFT`; 06h with defaults).
- R3: After `cmd_done` is sampled, the next request (or `ready`) follows exactly after the wait that belongs to the finished command, with `cmd_req` and `ready` low meanwhile. The waits are:
  - `CLR_WAIT` cycles after the clear byte;
  - `DATA_WAIT` cycles after a character write;
  - `CMD_WAIT` cycles after any other command.
- R4: `cmd_req`, `cmd_rs` and `cmd_byte` hold steady until `cmd_done` is sampled. `cmd_req` falls in the following cycle.
- R5: `ready` rises only after the wait that follows the entry byte, or the wait that follows a character write. `ready` is never high together with `cmd_req`.
- R6: An accepted write issues two commands:
  - first, `80h | addr` with `cmd_rs`=0, where addr = base + column and the base is 00h, 40h, 14h or 54h for rows 0, 1, 2 and 3;
  - then the character with `cmd_rs`=1.
- R7: A write with row above 3 or column above 19, offered while ready, issues no command. `wr_err` is high for exactly the next cycle, and `ready` stays high.
- R8: `wr_valid` while `ready` is low is ignored: no command is issued and no error is raised.
- R9: A write offered in the very first cycle that `ready` is high is accepted. `cmd_req` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req | output | 1 | Request to the bus cycle generator |
| cmd_rs | output | 1 | 0 = command byte, 1 = character data |
| cmd_byte | output | 8 | Byte to transfer |
| cmd_done | input | 1 | One-cycle completion from the bus cycle generator |
| wr_valid | input | 1 | Character write offered |
| wr_row | input | ROW_W | Zero-based row index |
| wr_col | input | COL_W | Zero-based column index |
| wr_char | input | 8 | Character code |
| ready | output | 1 | Set-up complete and idle; writes accepted |
| wr_err | output | 1 | One-cycle pulse for a refused position |

## Verification
The tightest coincidence is the end of a post-write wait meeting the next write request. The wait expiring and a new acceptance land in the same cycle, because the bench offers each write on the first falling edge at which `ready` is seen high. The reference model then expects the address command exactly one cycle later and nothing in between.

A second overlap is a refused position arriving while `ready` is high. Here the error pulse and the ready hold must coexist: the model expects `wr_err` in the next cycle while `ready` stays up and no request appears. Writes held during power-up and during an in-flight transfer check that acceptance and error logic stay silent when not ready.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    S_PWRUP,
    S_REQ,
    S_WAIT,
    S_READY
  } seq_state_e;

  typedef enum logic [2:0] {
    ST_FUNC,
    ST_DISP,
    ST_CLR,
    ST_ENTRY,
    ST_ADDR,
    ST_DATA
  } seq_step_e;

  localparam logic [7:0] CLEAR_BYTE = 8'h01;

  function automatic logic [7:0] func_set_byte(input bit two_line, input bit big_font);
    return {4'b0011, two_line, big_font, 2'b00};
  endfunction

  function automatic logic [7:0] disp_ctrl_byte(input bit disp_on, input bit cur_on, input bit blink_on);
    return {5'b00001, disp_on, cur_on, blink_on};
  endfunction

  function automatic logic [7:0] entry_byte(input bit incr, input bit shift);
    return {6'b000001, incr, shift};
  endfunction

  function automatic logic [7:0] ddram_set_byte(input logic [6:0] addr);
    return {1'b1, addr};
  endfunction

  // Row start inside display memory: odd rows live in the upper half,
  // rows 2 and 3 continue their upper/lower partner one row-width on.
  function automatic logic [6:0] row_base(input logic [1:0] row, input int unsigned cols);
    logic [6:0] base;
    case (row)
      2'd0:    base = 7'h00;
      2'd1:    base = 7'h40;
      2'd2:    base = 7'(cols);
      default: base = 7'h40 + 7'(cols);
    endcase
    return base;
  endfunction

  function automatic seq_step_e next_step(input seq_step_e s);
    seq_step_e n;
    case (s)
      ST_FUNC:  n = ST_DISP;
      ST_DISP:  n = ST_CLR;
      ST_CLR:   n = ST_ENTRY;
      ST_ADDR:  n = ST_DATA;
      default:  n = ST_FUNC;
    endcase
    return n;
  endfunction

  function automatic bit step_is_last(input seq_step_e s);
    return (s == ST_ENTRY) || (s == ST_DATA);
  endfunction

endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer #(
  parameter int              CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= RST_VAL;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: the wait shrinks by exactly one per cycle until it runs out
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

  // R3: a freshly loaded wait of more than one cycle is not yet over
  a_r3_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/lcdseq_addr_map.sv
module lcdseq_addr_map
  import lcdseq_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 5,
  parameter int ROWS  = 4,
  parameter int COLS  = 20
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             in_range,
  output logic [6:0]       ddaddr
);

  logic row_ok;
  logic col_ok;

  assign row_ok   = (int'(row) < ROWS);
  assign col_ok   = (int'(col) < COLS);
  assign in_range = row_ok && col_ok;
  assign ddaddr   = row_base(row[1:0], COLS) + 7'(col);

  // R6: a legal position always lands inside one of the two memory halves
  always_comb begin
    if (in_range) begin
      a_r6_addr_window: assert ((ddaddr < 7'(2 * COLS)) ||
                                (ddaddr >= 7'h40 && ddaddr < 7'h40 + 7'(2 * COLS)));
    end
  end

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CMD_WAIT  = 4,
  parameter int CLR_WAIT  = 8,
  parameter int DATA_WAIT = 4,
  parameter bit TWO_LINE  = 1'b1,
  parameter bit BIG_FONT  = 1'b0,
  parameter bit DISP_ON   = 1'b1,
  parameter bit CURSOR_ON = 1'b0,
  parameter bit BLINK_ON  = 1'b0,
  parameter bit INCR      = 1'b1,
  parameter bit SHIFT     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cmd_req,
  output logic             cmd_rs,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_done,
  input  logic             wr_valid,
  input  logic             wr_inrange,
  input  logic [6:0]       wr_ddaddr,
  input  logic [7:0]       wr_char,
  output logic             ready,
  output logic             wr_err
);

  seq_state_e state;
  seq_step_e  step;
  logic [6:0] addr_q;
  logic [7:0] char_q;
  logic       err_q;
  logic       init_done;

  logic done_evt;
  logic wait_over;
  logic pwr_over;
  logic accept_ok;
  logic accept_bad;

  assign done_evt   = (state == S_REQ) && cmd_done;
  assign wait_over  = (state == S_WAIT) && tmr_expired;
  assign pwr_over   = (state == S_PWRUP) && tmr_expired;
  assign accept_ok  = (state == S_READY) && wr_valid && wr_inrange;
  assign accept_bad = (state == S_READY) && wr_valid && !wr_inrange;

  function automatic logic [CNT_W-1:0] wait_len(input seq_step_e s);
    logic [CNT_W-1:0] w;
    case (s)
      ST_CLR:  w = CNT_W'(CLR_WAIT - 1);
      ST_DATA: w = CNT_W'(DATA_WAIT - 1);
      default: w = CNT_W'(CMD_WAIT - 1);
    endcase
    return w;
  endfunction

  always_comb begin
    case (step)
      ST_FUNC:  cmd_byte = func_set_byte(TWO_LINE, BIG_FONT);
      ST_DISP:  cmd_byte = disp_ctrl_byte(DISP_ON, CURSOR_ON, BLINK_ON);
      ST_CLR:   cmd_byte = CLEAR_BYTE;
      ST_ENTRY: cmd_byte = entry_byte(INCR, SHIFT);
      ST_ADDR:  cmd_byte = ddram_set_byte(addr_q);
      default:  cmd_byte = char_q;
    endcase
  end

  assign cmd_rs   = (step == ST_DATA);
  assign cmd_req  = (state == S_REQ);
  assign ready    = (state == S_READY);
  assign wr_err   = err_q;
  assign tmr_load = done_evt;
  assign tmr_val  = wait_len(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PWRUP;
      step      <= ST_FUNC;
      addr_q    <= '0;
      char_q    <= '0;
      err_q     <= 1'b0;
      init_done <= 1'b0;
    end else begin
      err_q <= accept_bad;
      case (state)
        S_PWRUP: if (pwr_over) state <= S_REQ;
        S_REQ:   if (done_evt) state <= S_WAIT;
        S_WAIT: begin
          if (wait_over) begin
            if (step_is_last(step)) begin
              state     <= S_READY;
              init_done <= 1'b1;
            end else begin
              step  <= next_step(step);
              state <= S_REQ;
            end
          end
        end
        default: begin
          if (accept_ok) begin
            addr_q <= wr_ddaddr;
            char_q <= wr_char;
            step   <= ST_ADDR;
            state  <= S_REQ;
          end
        end
      endcase
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> cmd_req);

  a_r4_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> $stable({cmd_rs, cmd_byte}));

  a_r4_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_done) |=> !cmd_req);

  a_r5_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && cmd_req));

  a_r5_ready_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tmr_expired));

  a_r7_err_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ready);

  a_r8_idle_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wr_valid) |=> !wr_err);

  a_r2_init_is_command: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !init_done) |-> !cmd_rs);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq #(
  parameter int PWRUP_CYC = 1_500_000,
  parameter int CMD_WAIT  = 1_950,
  parameter int CLR_WAIT  = 76_500,
  parameter int DATA_WAIT = 2_150,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 5,
  parameter int ROWS      = 4,
  parameter int COLS      = 20,
  parameter bit TWO_LINE  = 1'b1,
  parameter bit BIG_FONT  = 1'b0,
  parameter bit DISP_ON   = 1'b1,
  parameter bit CURSOR_ON = 1'b0,
  parameter bit BLINK_ON  = 1'b0,
  parameter bit INCR      = 1'b1,
  parameter bit SHIFT     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             cmd_req,
  output logic             cmd_rs,
  output logic [7:0]       cmd_byte,
  input  logic             cmd_done,
  input  logic             wr_valid,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [7:0]       wr_char,
  output logic             ready,
  output logic             wr_err
);

  localparam int MAX_A    = (PWRUP_CYC > CLR_WAIT) ? PWRUP_CYC : CLR_WAIT;
  localparam int MAX_B    = (CMD_WAIT > DATA_WAIT) ? CMD_WAIT : DATA_WAIT;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             wr_inrange;
  logic [6:0]       wr_ddaddr;

  lcdseq_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (CNT_W'(PWRUP_CYC - 1))
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  lcdseq_addr_map #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .ROWS  (ROWS),
    .COLS  (COLS)
  ) u_map (
    .row      (wr_row),
    .col      (wr_col),
    .in_range (wr_inrange),
    .ddaddr   (wr_ddaddr)
  );

  lcdseq_ctrl #(
    .CNT_W     (CNT_W),
    .CMD_WAIT  (CMD_WAIT),
    .CLR_WAIT  (CLR_WAIT),
    .DATA_WAIT (DATA_WAIT),
    .TWO_LINE  (TWO_LINE),
    .BIG_FONT  (BIG_FONT),
    .DISP_ON   (DISP_ON),
    .CURSOR_ON (CURSOR_ON),
    .BLINK_ON  (BLINK_ON),
    .INCR      (INCR),
    .SHIFT     (SHIFT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cmd_req     (cmd_req),
    .cmd_rs      (cmd_rs),
    .cmd_byte    (cmd_byte),
    .cmd_done    (cmd_done),
    .wr_valid    (wr_valid),
    .wr_inrange  (wr_inrange),
    .wr_ddaddr   (wr_ddaddr),
    .wr_char     (wr_char),
    .ready       (ready),
    .wr_err      (wr_err)
  );

endmodule

// File: tb/lcd_init_seq_bench.sv
`timescale 1ns/1ps
module lcd_init_seq_bench;

  localparam int PW = 200;
  localparam int CW = 20;
  localparam int LW = 60;
  localparam int DW = 25;

  localparam int M_WAIT  = 0;
  localparam int M_REQ   = 1;
  localparam int M_READY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_req;
  logic       cmd_rs;
  logic [7:0] cmd_byte;
  logic       cmd_done = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_row = '0;
  logic [4:0] wr_col = '0;
  logic [7:0] wr_char = '0;
  logic       ready;
  logic       wr_err;

  int checks = 0;
  int fails  = 0;

  lcd_init_seq #(
    .PWRUP_CYC (PW),
    .CMD_WAIT  (CW),
    .CLR_WAIT  (LW),
    .DATA_WAIT (DW)
  ) u_lcd_init_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_req  (cmd_req),
    .cmd_rs   (cmd_rs),
    .cmd_byte (cmd_byte),
    .cmd_done (cmd_done),
    .wr_valid (wr_valid),
    .wr_row   (wr_row),
    .wr_col   (wr_col),
    .wr_char  (wr_char),
    .ready    (ready),
    .wr_err   (wr_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected memory address: bench's own arithmetic for the row layout
  function automatic int exp_addr(input int r, input int c);
    return (r % 2) * 64 + (r / 2) * 20 + c;
  endfunction

  // Reference model state
  logic [8:0] q_cmd[$];
  int         q_wait[$];
  logic [8:0] cur_cmd;
  int         cur_wait;
  int         mode   = M_WAIT;
  int         since  = 0;
  int         target = PW;
  int         lat    = 0;
  bit         err_exp = 1'b0;

  initial begin
    // R2: set-up commands with their waits
    q_cmd.push_back({1'b0, 8'h38}); q_wait.push_back(CW);
    q_cmd.push_back({1'b0, 8'h0C}); q_wait.push_back(CW);
    q_cmd.push_back({1'b0, 8'h01}); q_wait.push_back(LW);
    q_cmd.push_back({1'b0, 8'h06}); q_wait.push_back(CW);
  end

  always @(posedge clk or negedge clk) begin
    if (clk) begin
      err_exp = 1'b0;
      if (rst_n && mode == M_READY && wr_valid) begin
        if (wr_row > 3 || wr_col > 19) begin
          err_exp = 1'b1;
        end else begin
          q_cmd.push_back({1'b0, 8'h80 | 8'(exp_addr(int'(wr_row), int'(wr_col)))});
          q_wait.push_back(CW);
          q_cmd.push_back({1'b1, wr_char});
          q_wait.push_back(DW);
          mode   = M_WAIT;
          since  = 0;
          target = 1;
        end
      end
    end else begin
      cmd_done = 1'b0;
      if (!rst_n) begin
        chk(!cmd_req && !ready && !wr_err, "R1 reset outputs", {cmd_req, ready, wr_err}, 0);
      end else begin
        chk(wr_err == err_exp, "R7 R8 error pulse", wr_err, err_exp);
        case (mode)
          M_WAIT: begin
            since++;
            if (since < target) begin
              chk(!cmd_req && !ready, "R1 R3 R8 quiet during wait", {cmd_req, ready}, 0);
            end else if (q_cmd.size() > 0) begin
              chk(cmd_req, "R3 request on time", cmd_req, 1);
              if (cmd_req) begin
                cur_cmd  = q_cmd.pop_front();
                cur_wait = q_wait.pop_front();
                chk({cmd_rs, cmd_byte} == cur_cmd, "R2 R6 command byte", {cmd_rs, cmd_byte}, cur_cmd);
                mode = M_REQ;
                lat  = 2;
              end
            end else begin
              chk(ready && !cmd_req, "R5 ready after final wait", {ready, cmd_req}, 2);
              if (ready) mode = M_READY;
            end
          end
          M_REQ: begin
            chk(cmd_req && {cmd_rs, cmd_byte} == cur_cmd, "R4 request held steady",
                {cmd_req, cmd_rs, cmd_byte}, {1'b1, cur_cmd});
            if (lat == 0) begin
              cmd_done = 1'b1;
              mode     = M_WAIT;
              since    = 0;
              target   = cur_wait + 1;
            end else begin
              lat--;
            end
          end
          default: begin
            chk(ready && !cmd_req, "R5 ready holds while idle", {ready, cmd_req}, 2);
          end
        endcase
      end
    end
  end

  task automatic do_write(input int r, input int c, input logic [7:0] ch);
    bit good;
    good = (r <= 3) && (c <= 19);
    do @(negedge clk); while (!ready);
    wr_row   = 3'(r);
    wr_col   = 5'(c);
    wr_char  = ch;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    if (good) chk(cmd_req, "R9 write taken on first ready cycle", cmd_req, 1);
    else      chk(ready && !cmd_req, "R7 refused write keeps ready", {ready, cmd_req}, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #5 rst_n = 1'b1;
    // R8: a write held during the power-up wait must be ignored
    wr_row = 3'd1; wr_col = 5'd2; wr_char = 8'h5A; wr_valid = 1'b1;
    repeat (30) @(negedge clk);
    wr_valid = 1'b0;

    do_write(0, 0, 8'h41);    // R6 row 0 start
    do_write(1, 19, 8'h42);   // R6 row 1 end -> 53h
    // R8: write offered while the previous one is in flight
    @(negedge clk);
    wr_row = 3'd6; wr_col = 5'd0; wr_valid = 1'b1;
    repeat (5) @(negedge clk);
    wr_valid = 1'b0;
    do_write(3, 0, 8'h43);    // R6 row 3 -> 54h
    do_write(2, 19, 8'h44);   // R6 row 2 end -> 27h
    do_write(4, 0, 8'h45);    // R7 row too large
    do_write(0, 20, 8'h46);   // R7 column too large
    do_write(7, 31, 8'h47);   // R7 both too large
    do_write(2, 0, 8'h48);    // R6 row 2 start -> 14h
    do_write(3, 19, 8'h49);   // R6 last cell -> 67h

    do @(negedge clk); while (!ready);
    repeat (3) @(negedge clk);
    chk(q_cmd.size() == 0, "R6 every expected command issued", q_cmd.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule